// File: doc/BRIEF.md
# Multipurpose I/O Port Controller

This block manages a small bank of general-purpose pins, eight by default, through five byte-wide registers. Each pin can be set as an input or an output. Each pin also has its own high-impedance override, which works separately from the direction choice, plus an input polarity flip and an interrupt enable. One register behaves differently on write and on read. A write sets the levels driven on the output pins. A read returns the levels seen on the input pins.

Pin inputs pass through a two-flop synchronizer before any other logic uses them. One interrupt request line goes high while any pin meets three conditions: it is set as an input, it is enabled for interrupts, and it reads high after its optional inversion. The host side is a plain strobe interface: an address, a write strobe with write data, and combinational read data for the addressed register. The pad side gives an output level vector and an output-enable vector for each pin.

Top module: `mpio_port`

## Requirements
- R1: After a synchronous reset, every register holds zero. All pins are then inputs, `pin_oe` and `pin_out` are 0x00, and `irq` is low.
- R2: Register addresses are fixed as follows. 0 is the level register, 1 is direction (bit=1 means output), 2 is high-impedance, 3 is inversion, and 4 is interrupt enable. Reads of addresses 5 to 7 return 0x00, and writes to them change no register.
- R3: A write to address 0 appears on `pin_out` from the cycle after the write strobe.
- R4: A pin drives (`pin_oe`=1) only when its direction bit is 1 and its high-impedance bit is 0.
- R5: A change on `pin_in` reaches readback and `irq` after exactly two clock edges. After only one edge, the old value is still reported.
- R6: An inversion bit of 1 flips the synchronized input of that pin. The flip applies both to its level readback and to its interrupt evaluation.
- R7: Reading address 0 gives a mixed value. Bits for output pins return the last written level, without inversion. Bits for input pins return the synchronized, inverted input.
- R8: `irq` is high exactly when at least one pin is an input, has its interrupt-enable bit set, and is high after inversion.
- R9: Reads of addresses 1 to 4 return the value last written to that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register (combinational) |
| pin_in | input | 8 | Raw pad input levels |
| pin_out | output | 8 | Output levels to pads |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The two events that can fall in the same clock edge are a register write that changes inversion or enable, and a synchronized input change that reaches the interrupt logic. The bench sets up this collision as follows. It drives a new `pin_in` value, waits one edge, and then times a write to the inversion register so that it lands on the edge where the second synchronizer flop updates. The resulting `irq` and readback are then compared with a value computed from the new input and the new inversion taken together. A sweep over 16 arithmetic configurations and all 256 input patterns judges R6 to R8 in every combination.

// File: rtl/mpio_pkg.sv
package mpio_pkg;

    typedef enum logic [2:0] {
        ADR_LEVEL = 3'd0,
        ADR_DIR   = 3'd1,
        ADR_HIZ   = 3'd2,
        ADR_INV   = 3'd3,
        ADR_IEN   = 3'd4
    } reg_addr_e;

    // Per-pin control bundle carried between submodules
    typedef struct packed {
        logic dir;
        logic hiz;
        logic inv;
        logic ien;
        logic lvl;
    } pin_cfg_t;

    function automatic logic addr_hit(input logic [2:0] a, input reg_addr_e r);
        return a == 3'(r);
    endfunction

endpackage

// File: rtl/mpio_regfile.sv
module mpio_regfile
    import mpio_pkg::*;
#(
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        reg_addr,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    output pin_cfg_t          cfg [PORT_W]
);

    logic [PORT_W-1:0] lvl_q, dir_q, hiz_q, inv_q, ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            dir_q <= '0;
            hiz_q <= '0;
            inv_q <= '0;
            ien_q <= '0;
        end else if (wr_en) begin
            if (addr_hit(reg_addr, ADR_LEVEL)) lvl_q <= wr_data;
            if (addr_hit(reg_addr, ADR_DIR))   dir_q <= wr_data;
            if (addr_hit(reg_addr, ADR_HIZ))   hiz_q <= wr_data;
            if (addr_hit(reg_addr, ADR_INV))   inv_q <= wr_data;
            if (addr_hit(reg_addr, ADR_IEN))   ien_q <= wr_data;
        end
    end

    for (genvar i = 0; i < PORT_W; i++) begin : g_cfg
        assign cfg[i] = '{dir: dir_q[i], hiz: hiz_q[i], inv: inv_q[i],
                          ien: ien_q[i], lvl: lvl_q[i]};
    end

    // R2: a write to an unmapped address leaves every register unchanged
    assert_unmapped_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr > 3'd4) |=> $stable({lvl_q, dir_q, hiz_q, inv_q, ien_q}));

endmodule

// File: rtl/mpio_sync.sv
module mpio_sync #(
    parameter int unsigned PORT_W = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] d_in,
    output logic [PORT_W-1:0] d_out
);

    logic [PORT_W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign d_out = stage_q[STAGES-1];

    // R5: the last stage follows the stage ahead of it by one edge
    if (STAGES > 1) begin : g_chk
        assert_sync_chain_R5: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> d_out == $past(stage_q[STAGES-2]));
    end

endmodule

// File: rtl/mpio_pin_logic.sv
module mpio_pin_logic
    import mpio_pkg::*;
#(
    parameter int unsigned PORT_W = 8
) (
    input  pin_cfg_t          cfg [PORT_W],
    input  logic [PORT_W-1:0] sync_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] level_rd,
    output logic              irq
);

    logic [PORT_W-1:0] eff_in;
    logic [PORT_W-1:0] irq_src;

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        assign eff_in[i]   = sync_in[i] ^ cfg[i].inv;
        assign pad_out[i]  = cfg[i].lvl;
        assign pad_oe[i]   = cfg[i].dir & ~cfg[i].hiz;
        assign level_rd[i] = cfg[i].dir ? cfg[i].lvl : eff_in[i];
        assign irq_src[i]  = ~cfg[i].dir & cfg[i].ien & eff_in[i];
    end

    assign irq = |irq_src;

endmodule

// File: rtl/mpio_port.sv
module mpio_port
    import mpio_pkg::*;
#(
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        reg_addr,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic              irq
);

    pin_cfg_t          cfg [PORT_W];
    logic [PORT_W-1:0] sync_in;
    logic [PORT_W-1:0] level_rd;
    logic [PORT_W-1:0] dir_v, hiz_v, inv_v, ien_v;

    mpio_regfile #(.PORT_W(PORT_W)) regs_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .cfg(cfg)
    );

    mpio_sync #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d_in(pin_in), .d_out(sync_in)
    );

    mpio_pin_logic #(.PORT_W(PORT_W)) pins_i (
        .cfg(cfg), .sync_in(sync_in), .pad_out(pin_out), .pad_oe(pin_oe),
        .level_rd(level_rd), .irq(irq)
    );

    for (genvar i = 0; i < PORT_W; i++) begin : g_rb
        assign dir_v[i] = cfg[i].dir;
        assign hiz_v[i] = cfg[i].hiz;
        assign inv_v[i] = cfg[i].inv;
        assign ien_v[i] = cfg[i].ien;
    end

    always_comb begin
        unique case (reg_addr)
            3'(ADR_LEVEL): rd_data = level_rd;
            3'(ADR_DIR):   rd_data = dir_v;
            3'(ADR_HIZ):   rd_data = hiz_v;
            3'(ADR_INV):   rd_data = inv_v;
            3'(ADR_IEN):   rd_data = ien_v;
            default:       rd_data = '0;
        endcase
    end

    // R1: the cycle after reset nothing drives and no interrupt is raised
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && !irq));

    // R3: a level write shows on the pads one cycle later
    assert_level_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 3'(ADR_LEVEL)) |=> pin_out == $past(wr_data));

    // R4: forcing every pin to high impedance removes all drive
    assert_hiz_all_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 3'(ADR_HIZ) && wr_data == '1) |=> pin_oe == '0);

    // R8: clearing all interrupt enables silences the request
    assert_ien_off_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 3'(ADR_IEN) && wr_data == '0) |=> !irq);

endmodule

// File: tb/mpio_port_tb.sv
module mpio_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_lvl, m_dir, m_hiz, m_inv, m_ien;

    always #2 clk = ~clk;

    mpio_port dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [7:0] exp_level(input logic [7:0] p);
        return (m_dir & m_lvl) | (~m_dir & (p ^ m_inv));
    endfunction

    function automatic logic exp_irq(input logic [7:0] p);
        return |(~m_dir & m_ien & (p ^ m_inv));
    endfunction

    task automatic load_cfg(input logic [7:0] l, input logic [7:0] d, input logic [7:0] h,
                            input logic [7:0] v, input logic [7:0] e);
        m_lvl = l; m_dir = d; m_hiz = h; m_inv = v; m_ien = e;
        wr(3'd0, l); wr(3'd1, d); wr(3'd2, h); wr(3'd3, v); wr(3'd4, e);
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 out", pin_out, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), r);
            chk("R1 reg", r, 8'h00);
        end

        // R9 readback of control registers
        load_cfg(8'hC3, 8'hA5, 8'h0F, 8'h3C, 8'h96);
        rd(3'd1, r); chk("R9 dir", r, 8'hA5);
        rd(3'd2, r); chk("R9 hiz", r, 8'h0F);
        rd(3'd3, r); chk("R9 inv", r, 8'h3C);
        rd(3'd4, r); chk("R9 ien", r, 8'h96);

        // R2 unmapped addresses
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 8'hFF);
            rd(3'(a), r); chk("R2 unmapped read", r, 8'h00);
        end
        rd(3'd1, r); chk("R2 dir kept", r, 8'hA5);
        rd(3'd2, r); chk("R2 hiz kept", r, 8'h0F);
        rd(3'd3, r); chk("R2 inv kept", r, 8'h3C);
        rd(3'd4, r); chk("R2 ien kept", r, 8'h96);
        chk("R2 out kept", pin_out, 8'hC3);

        // R5 synchronizer latency: all inputs, no inversion
        load_cfg(8'h00, 8'h00, 8'h00, 8'h00, 8'hFF);
        @(negedge clk); pin_in = 8'h5A;
        @(negedge clk);
        rd(3'd0, r); chk("R5 one edge", r, 8'h00);
        chk("R5 irq one edge", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rd(3'd0, r); chk("R5 two edges", r, 8'h5A);
        chk("R5 irq two edges", {7'd0, irq}, 8'h01);

        // R8/R6 collision: inversion write lands with the synced input change
        @(negedge clk); pin_in = 8'h01;
        @(negedge clk);
        reg_addr = 3'd3; wr_en = 1'b1; wr_data = 8'hFE;
        @(negedge clk);
        wr_en = 1'b0; m_inv = 8'hFE;
        rd(3'd0, r); chk("R6 collision level", r, exp_level(8'h01));
        chk("R8 collision irq", {7'd0, irq}, {7'd0, exp_irq(8'h01)});

        // R3 R4 R6 R7 R8 sweep
        for (int c = 0; c < 16; c++) begin
            load_cfg(8'(c * 29 + 7), 8'(c * 37) ^ 8'h5A, 8'(c * 53 + 3),
                     8'(c * 91) ^ 8'hC3, 8'(c * 17 + 240));
            chk("R3 pin_out", pin_out, m_lvl);
            chk("R4 pin_oe", pin_oe, m_dir & ~m_hiz);
            for (int p = 0; p < 256; p++) begin
                @(negedge clk); pin_in = 8'(p);
                @(negedge clk);
                @(negedge clk);
                rd(3'd0, r);
                chk("R7 level readback R6", r, exp_level(8'(p)));
                chk("R8 irq", {7'd0, irq}, {7'd0, exp_irq(8'(p))});
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule